// File: doc/BRIEF.md
# Compositional Regular Expression Matcher

This block recognises the fixed pattern `(ε + C)* + (A.B)` over three one-bit symbol lines, taking one symbol set per clock cycle. A pulse on the start input opens a match attempt at that cycle. From then on, the block reports through two outputs whether the symbols seen since that start form a word of the pattern (`match_o`) and whether some attempt is still alive and could still succeed (`prefix_o`).

The circuit is assembled from small construct cells: empty word, single symbol, concatenation, alternation and zero-or-more repetition. Each cell has one start input and exports a match flag, a prefix flag and a flag marking matches that consumed at least one symbol. No state register encodes the pattern as a whole. A new start may be pulsed while earlier attempts are still running, and the outputs report the union of all live attempts.

Timing convention: if start is high in cycle t and the word uses the symbols of cycles t .. t+n-1, the match appears in cycle t+n. The empty word therefore matches in cycle t itself, combinationally from start.

Top module: `re_matcher`

## Requirements
- R1: While rst_ni is low all internal flops clear. After reset is released, with start_i held low, match_o and prefix_o are 0 whatever the symbols are, even if an attempt was running when reset was asserted.
- R2: In any cycle where start_i is 1, match_o and prefix_o are both 1 in that same cycle (empty repetition).
- R3: If start_i is 1 in cycle t and sym_c_i is 1 in every cycle t .. k-1, then match_o is 1 in cycle k, for any run length.
- R4: A match that does not come from start_i in the same cycle needs an attempt that was alive in the previous cycle. A run of C ends the cycle after sym_c_i is low.
- R5: If start_i and sym_a_i are 1 in cycle t and sym_b_i is 1 in cycle t+1, then match_o is 1 in cycle t+2.
- R6: If start_i and sym_a_i are 1 in cycle t, then prefix_o is 1 in cycle t+1.
- R7: Overlapping attempts are independent. The outputs in each cycle are the OR over every start since reset of that attempt's own match and prefix.
- R8: If start_i is 0 and prefix_o was 0 in the previous cycle, then match_o and prefix_o are 0. Symbols alone are ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock, rising edge |
| rst_ni | input | 1 | Asynchronous reset, active low |
| start_i | input | 1 | Opens a match attempt in this cycle |
| sym_a_i | input | 1 | Symbol line A |
| sym_b_i | input | 1 | Symbol line B |
| sym_c_i | input | 1 | Symbol line C |
| match_o | output | 1 | Some attempt has matched a complete word |
| prefix_o | output | 1 | Some attempt is alive and not yet failed |

## Verification
The properties assume that start_i is held low while reset is asserted, so that the first cycle after release sees no attempt left over from before. The bench keeps start_i low during every reset, including a reset asserted in the middle of a long run of C. Outside reset, start_i and the symbols are unconstrained. The stimulus covers every pattern of the four inputs over three cycles, followed by a pseudo-random stream in which attempts overlap freely.

// File: rtl/re_pkg.sv
package re_pkg;
  // late: a match reached after consuming at least one symbol
  typedef struct packed {
    logic match;
    logic late;
    logic prefix;
  } re_out_t;
endpackage

// File: rtl/re_empty_cell.sv
module re_empty_cell
  import re_pkg::*;
(
  input  logic    start_i,
  output re_out_t out_o
);
  always_comb begin
    out_o.match  = start_i;
    out_o.late   = 1'b0;
    out_o.prefix = 1'b0;
  end
endmodule

// File: rtl/re_sym_cell.sv
module re_sym_cell
  import re_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    start_i,
  input  logic    sym_i,
  output re_out_t out_o
);
  logic hit_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) hit_q <= 1'b0;
    else         hit_q <= start_i & sym_i;
  end

  always_comb begin
    out_o.match  = hit_q;
    out_o.late   = hit_q;
    out_o.prefix = start_i;
  end
endmodule

// File: rtl/re_seq_cell.sv
module re_seq_cell
  import re_pkg::*;
(
  input  re_out_t head_i,
  input  re_out_t tail_i,
  output logic    tail_start_o,
  output re_out_t out_o
);
  assign tail_start_o = head_i.match;

  always_comb begin
    out_o.match  = tail_i.match;
    // consumed if the tail consumed, or the tail matched off a consumed head
    out_o.late   = tail_i.late | (tail_i.match & head_i.late);
    out_o.prefix = head_i.prefix | tail_i.prefix;
  end
endmodule

// File: rtl/re_choice_cell.sv
module re_choice_cell
  import re_pkg::*;
#(
  parameter int unsigned N_ARM = 2
) (
  input  re_out_t [N_ARM-1:0] arm_i,
  output re_out_t             out_o
);
  always_comb begin
    out_o = '0;
    for (int i = 0; i < N_ARM; i++) begin
      out_o.match  = out_o.match  | arm_i[i].match;
      out_o.late   = out_o.late   | arm_i[i].late;
      out_o.prefix = out_o.prefix | arm_i[i].prefix;
    end
  end
endmodule

// File: rtl/re_loop_cell.sv
module re_loop_cell
  import re_pkg::*;
(
  input  logic    start_i,
  input  re_out_t body_i,
  output logic    body_start_o,
  output re_out_t out_o
);
  // only consumed matches re-arm the body: no zero-delay feedback
  assign body_start_o = start_i | body_i.late;

  always_comb begin
    out_o.match  = start_i | body_i.match;
    out_o.late   = body_i.late;
    out_o.prefix = body_i.prefix;
  end
endmodule

// File: rtl/re_matcher.sv
module re_matcher
  import re_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic start_i,
  input  logic sym_a_i,
  input  logic sym_b_i,
  input  logic sym_c_i,
  output logic match_o,
  output logic prefix_o
);
  localparam int unsigned N_BODY_ARM = 2;
  localparam int unsigned N_TOP_ARM  = 2;

  // left arm: (eps + C)*
  logic                        body_start;
  re_out_t                     eps_out, c_out, body_out, loop_out;
  re_out_t [N_BODY_ARM-1:0]    body_arms;

  re_empty_cell u_eps (
    .start_i (body_start),
    .out_o   (eps_out)
  );

  re_sym_cell u_sym_c (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (body_start),
    .sym_i   (sym_c_i),
    .out_o   (c_out)
  );

  assign body_arms = {c_out, eps_out};

  re_choice_cell #(.N_ARM(N_BODY_ARM)) u_body_alt (
    .arm_i (body_arms),
    .out_o (body_out)
  );

  re_loop_cell u_loop (
    .start_i      (start_i),
    .body_i       (body_out),
    .body_start_o (body_start),
    .out_o        (loop_out)
  );

  // right arm: A.B
  logic    b_start;
  re_out_t a_out, b_out, ab_out;

  re_sym_cell u_sym_a (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (start_i),
    .sym_i   (sym_a_i),
    .out_o   (a_out)
  );

  re_sym_cell u_sym_b (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .start_i (b_start),
    .sym_i   (sym_b_i),
    .out_o   (b_out)
  );

  re_seq_cell u_ab (
    .head_i       (a_out),
    .tail_i       (b_out),
    .tail_start_o (b_start),
    .out_o        (ab_out)
  );

  // root alternation
  re_out_t                  root_out;
  re_out_t [N_TOP_ARM-1:0]  top_arms;

  assign top_arms = {ab_out, loop_out};

  re_choice_cell #(.N_ARM(N_TOP_ARM)) u_root_alt (
    .arm_i (top_arms),
    .out_o (root_out)
  );

  assign match_o  = root_out.match | root_out.late;
  assign prefix_o = root_out.prefix;

endmodule

// File: rtl/re_matcher_chk.sv
module re_matcher_chk (
  input logic clk_i,
  input logic rst_ni,
  input logic start_i,
  input logic sym_a_i,
  input logic sym_b_i,
  input logic sym_c_i,
  input logic match_o,
  input logic prefix_o
);
  p_empty_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start_i |-> (match_o && prefix_o));

  p_c_step_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start_i && sym_c_i) |=> match_o);

  p_alive_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (match_o && !start_i) |-> $past(prefix_o));

  p_ab_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($past(start_i && sym_a_i) && sym_b_i) |=> match_o);

  p_ab_pref_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(start_i && sym_a_i) |-> prefix_o);

  p_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!start_i && !$past(prefix_o)) |-> (!match_o && !prefix_o));
endmodule

bind re_matcher re_matcher_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .start_i  (start_i),
  .sym_a_i  (sym_a_i),
  .sym_b_i  (sym_b_i),
  .sym_c_i  (sym_c_i),
  .match_o  (match_o),
  .prefix_o (prefix_o)
);

// File: tb/tb_re_matcher.sv
`timescale 1ns/1ps
module tb_re_matcher;
  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic start_i = 1'b0, sym_a_i = 1'b0, sym_b_i = 1'b0, sym_c_i = 1'b0;
  logic match_o, prefix_o;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk_i = ~clk_i;  // 50 MHz

  re_matcher dut (.*);

  localparam int HL = 64;
  bit h_st[HL], h_a[HL], h_b[HL], h_c[HL];
  int k = 0, base = 0;
  bit prev_cst = 1'b0;

  function automatic bit at_st(int t); return h_st[t % HL]; endfunction
  function automatic bit at_a (int t); return h_a[t % HL];  endfunction
  function automatic bit at_b (int t); return h_b[t % HL];  endfunction
  function automatic bit at_c (int t); return h_c[t % HL];  endfunction

  // some start at t<k with C high on every cycle t..k-1
  function automatic bit c_run_alive(int kk);
    bit r = 1'b0;
    int lo = (kk - (HL - 1) > base) ? kk - (HL - 1) : base;
    for (int t = kk - 1; t >= lo; t--) begin
      if (!at_c(t)) break;
      if (at_st(t)) r = 1'b1;
    end
    return r;
  endfunction

  task automatic check(string tag, bit act, bit exp, string what);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s at cycle %0d: actual %0b expected %0b", tag, what, k, act, exp);
    end
  endtask

  task automatic step(bit st, bit a, bit b, bit c);
    bit cst, ab_m, ab_p, exp_m, exp_p;
    int n;
    string tag;
    @(negedge clk_i);
    start_i = st; sym_a_i = a; sym_b_i = b; sym_c_i = c;
    h_st[k % HL] = st; h_a[k % HL] = a; h_b[k % HL] = b; h_c[k % HL] = c;
    #5;
    cst   = c_run_alive(k);
    ab_m  = (k - 2 >= base) && at_st(k-2) && at_a(k-2) && at_b(k-1);
    ab_p  = (k - 1 >= base) && at_st(k-1) && at_a(k-1);
    exp_m = st | cst | ab_m;
    exp_p = st | cst | ab_p;
    n = int'(st) + int'(cst) + int'(ab_m);
    if (n > 1)        tag = "R7";
    else if (st)      tag = "R2";
    else if (ab_m)    tag = "R5";
    else if (cst)     tag = "R3";
    else if (prev_cst) tag = "R4";
    else              tag = "R8";
    check(tag, match_o, exp_m, "match");
    check(ab_p ? "R6" : tag, prefix_o, exp_p, "prefix");
    prev_cst = cst;
    k++;
  endtask

  initial begin
    logic [15:0] lfsr;
    #4_000_000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] lfsr;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    // R1: reset state, symbols without start
    step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b1, 1'b1, 1'b1);

    // R3: long C run then break (R4)
    step(1'b1, 1'b0, 1'b0, 1'b1);
    for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b0);
    step(1'b0, 1'b0, 1'b0, 1'b1);

    // R1: reset in the middle of a C run clears it
    step(1'b1, 1'b0, 1'b0, 1'b1);
    step(1'b0, 1'b0, 1'b0, 1'b1);
    @(negedge clk_i);
    start_i = 1'b0;
    rst_ni = 1'b0;
    @(negedge clk_i);
    rst_ni = 1'b1;
    base = k; prev_cst = 1'b0;
    #5;
    check("R1", match_o, 1'b0, "match after reset");
    check("R1", prefix_o, 1'b0, "prefix after reset");
    step(1'b0, 1'b1, 1'b1, 1'b1);
    step(1'b0, 1'b0, 1'b1, 1'b1);

    // exhaustive: every 3-cycle pattern of {start,a,b,c}, then idle flush
    for (int p = 0; p < 4096; p++) begin
      for (int j = 0; j < 3; j++) begin
        logic [3:0] v;
        v = 4'((p >> (4*j)) & 15);
        step(v[3], v[2], v[1], v[0]);
      end
      repeat (3) step(1'b0, 1'b0, 1'b0, 1'b0);
    end

    // pseudo-random overlapping stream
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      step(lfsr[0] & lfsr[5], lfsr[1], lfsr[2], lfsr[3] | lfsr[7]);
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule